// File: doc/BRIEF.md
# Keyed Object Sorter With Threshold Count

This block takes one event's worth of reconstructed objects, each a record of sixteen 8-bit quantities, and returns them in descending order of a key that is chosen at run time. A 16-bit selection mask names the quantities that take part. The key of an object is the sum of the quantities that the mask selects, so one mask bit picks a single field, such as an energy, a chamber index or a track count. Several bits together give a combined measure.

Objects arrive on a valid/last stream. Each accepted object is inserted into a register array in the cycle it arrives, so the array is already sorted when the last object of the event comes in. The block then sends the sorted list out, one object per cycle. In the cycle after the final object it gives a single-cycle pulse that carries the number of stored objects whose key reaches a programmable threshold. Several instances with different masks can run side by side on the same input stream.

Top module: `keyed_sorter`

## Requirements
- R1: After reset, out_valid and cnt_valid are low and in_ready is high. The mask register holds 16'h0001, which selects quantity 0 only, and the threshold register holds 0.
- R2: Quantity q of an object sits in in_obj bits [8q+7:8q]. The key is the zero-extended sum of every quantity q for which mask bit q is set. An all-zero mask gives key 0. out_key shows the key of the object currently on out_obj.
- R3: The objects of an event leave in non-increasing key order.
- R4: Objects with equal keys leave in the order in which they arrived.
- R5: While the block is filling, in_ready stays high and an object is accepted on every cycle that in_valid is high, with no gaps needed between objects.
- R6: The cycle after an object with in_last is accepted, output starts. out_valid is then high for exactly as many consecutive cycles as there are stored objects, and out_last marks the final one.
- R7: In the cycle after the object marked out_last, cnt_valid is high for one cycle. cnt_value then equals the number of stored objects whose key is greater than or equal to the threshold.
- R8: An event holds at most DEPTH (16) objects. Objects beyond the first DEPTH are discarded, and an in_last on a discarded object still closes the event.
- R9: in_ready is low while sorted objects or the count are being sent. in_valid is ignored during that time, so nothing offered then shows up in any later output.
- R10: A write with cfg_we loads the mask and the threshold. The new values apply to every object accepted after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the mask and threshold registers |
| cfg_mask | input | 16 | Quantity selection mask |
| cfg_thresh | input | 12 | Key threshold for the count |
| in_valid | input | 1 | Input object valid |
| in_ready | output | 1 | Block is accepting objects |
| in_obj | input | 128 | Input object record, sixteen 8-bit quantities |
| in_last | input | 1 | Final object of the event |
| out_valid | output | 1 | Sorted object valid |
| out_obj | output | 128 | Sorted object record |
| out_key | output | 12 | Key of the sorted object |
| out_last | output | 1 | Final sorted object |
| cnt_valid | output | 1 | Count valid pulse |
| cnt_value | output | 5 | Number of stored objects with key at or above the threshold |

## Verification
The main path is driven with a table of events that vary the mask in several ways: a single low bit, a single high bit, a pair of bits, a nibble, all bits, and no bits. Each event also has its own object count and threshold. The single-bit masks show that the right byte lane is selected, and the multi-bit masks show that the key is a sum rather than one field. The empty mask makes every key equal, so any reordering of equal keys becomes visible. A directed event alternates two key values that both repeat, with the other fields still distinguishing each object, which tests stable placement of ties. Further directed events check the following:
- the reset mask without any write
- a one-object event
- an over-full event, to show that objects past the limit are dropped
- input offered during output, to show that it is never stored

// File: rtl/ksort_pkg.sv
package ksort_pkg;

    localparam int NQ    = 16;                   // quantities per object
    localparam int QW    = 8;                    // bits per quantity
    localparam int DEPTH = 16;                   // objects per event
    localparam int OBJ_W = NQ * QW;
    localparam int KW    = QW + $clog2(NQ);      // key width, holds a full sum
    localparam int CW    = $clog2(DEPTH + 1);    // count width
    localparam int IW    = $clog2(DEPTH);        // slot index width

    typedef struct packed {
        logic [OBJ_W-1:0] obj;
        logic [KW-1:0]    key;
    } entry_t;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_COUNT = 2'd2
    } phase_t;

    function automatic logic [QW-1:0] quantity(input logic [OBJ_W-1:0] obj, input int q);
        return obj[q*QW +: QW];
    endfunction

endpackage

// File: rtl/key_former.sv
module key_former
    import ksort_pkg::*;
(
    input  logic [OBJ_W-1:0] obj,
    input  logic [NQ-1:0]    mask,
    output logic [KW-1:0]    key
);
    logic [KW-1:0] lane [NQ];

    for (genvar q = 0; q < NQ; q++) begin : g_lane
        assign lane[q] = mask[q] ? KW'(quantity(obj, q)) : '0;
    end

    always_comb begin
        key = '0;
        for (int q = 0; q < NQ; q++) begin
            key = key + lane[q];
        end
    end
endmodule

// File: rtl/insert_array.sv
module insert_array
    import ksort_pkg::*;
#(
    parameter int SLOTS = DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              ins_en,
    input  entry_t            ins_entry,
    input  logic [IW-1:0]     rd_idx,
    output entry_t            rd_entry,
    output logic              full,
    output logic [CW-1:0]     stored
);
    entry_t            slot_q [SLOTS];
    logic [SLOTS-1:0]  vld_q;
    logic [SLOTS-1:0]  stay;   // slot keeps its content: key ahead of or equal to new one
    logic              do_ins;

    assign full   = vld_q[SLOTS-1];
    assign do_ins = ins_en && !full;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        assign stay[i] = vld_q[i] && (slot_q[i].key >= ins_entry.key);

        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    vld_q[i] <= 1'b0;
                end else if (do_ins && !stay[i]) begin
                    slot_q[i] <= ins_entry;
                    vld_q[i]  <= 1'b1;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    vld_q[i] <= 1'b0;
                end else if (do_ins && !stay[i]) begin
                    if (stay[i-1]) begin
                        slot_q[i] <= ins_entry;
                        vld_q[i]  <= 1'b1;
                    end else begin
                        slot_q[i] <= slot_q[i-1];
                        vld_q[i]  <= vld_q[i-1];
                    end
                end
            end
        end
    end

    assign rd_entry = slot_q[rd_idx];
    assign stored   = CW'($countones(vld_q));
endmodule

// File: rtl/pass_counter.sv
module pass_counter
    import ksort_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          hit_en,
    input  logic [KW-1:0] key,
    input  logic [KW-1:0] thresh,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (hit_en && (key >= thresh)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/keyed_sorter.sv
module keyed_sorter
    import ksort_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [NQ-1:0]    cfg_mask,
    input  logic [KW-1:0]    cfg_thresh,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OBJ_W-1:0] in_obj,
    input  logic             in_last,
    output logic             out_valid,
    output logic [OBJ_W-1:0] out_obj,
    output logic [KW-1:0]    out_key,
    output logic             out_last,
    output logic             cnt_valid,
    output logic [CW-1:0]    cnt_value
);
    phase_t        phase_q;
    logic [NQ-1:0] mask_q;
    logic [KW-1:0] thresh_q;
    logic [IW-1:0] rd_q;
    logic [KW-1:0] new_key;
    entry_t        new_entry;
    entry_t        head;
    logic          accept;
    logic          full;
    logic          clr;
    logic [CW-1:0] stored;
    logic [CW-1:0] passed;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= NQ'(1);
            thresh_q <= '0;
        end else if (cfg_we) begin
            mask_q   <= cfg_mask;
            thresh_q <= cfg_thresh;
        end
    end

    key_former u_key (
        .obj  (in_obj),
        .mask (mask_q),
        .key  (new_key)
    );

    assign new_entry = '{obj: in_obj, key: new_key};
    assign in_ready  = (phase_q == ST_FILL);
    assign accept    = in_valid && in_ready;
    assign clr       = (phase_q == ST_COUNT);

    insert_array #(.SLOTS(DEPTH)) u_arr (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .ins_en    (accept),
        .ins_entry (new_entry),
        .rd_idx    (rd_q),
        .rd_entry  (head),
        .full      (full),
        .stored    (stored)
    );

    pass_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .hit_en (accept && !full),
        .key    (new_key),
        .thresh (thresh_q),
        .count  (passed)
    );

    assign out_valid = (phase_q == ST_DRAIN);
    assign out_obj   = head.obj;
    assign out_key   = head.key;
    assign out_last  = out_valid && (CW'(rd_q) == stored - 1'b1);
    assign cnt_valid = (phase_q == ST_COUNT);
    assign cnt_value = passed;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= ST_FILL;
            rd_q    <= '0;
        end else begin
            unique case (phase_q)
                ST_FILL: begin
                    rd_q <= '0;
                    if (accept && in_last) phase_q <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (out_last) phase_q <= ST_COUNT;
                    else          rd_q    <= rd_q + 1'b1;
                end
                ST_COUNT: phase_q <= ST_FILL;
                default:  phase_q <= ST_FILL;
            endcase
        end
    end
endmodule

// File: rtl/sorter_checker.sv
module sorter_checker
    import ksort_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic          in_last,
    input logic          out_valid,
    input logic          out_last,
    input logic [KW-1:0] out_key,
    input logic          cnt_valid,
    input logic [CW-1:0] cnt_value
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !cnt_valid && in_ready));

    p_descending_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> (out_key <= $past(out_key)));

    p_drain_start_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_last) |=> out_valid);

    p_count_follows_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |=> (cnt_valid && !out_valid));

    p_count_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_valid |=> !cnt_valid);

    p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
        cnt_valid |-> (cnt_value <= CW'(DEPTH)));

    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid || cnt_valid) |-> !in_ready);
endmodule

bind keyed_sorter sorter_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_key   (out_key),
    .cnt_valid (cnt_valid),
    .cnt_value (cnt_value)
);

// File: tb/sim_keyed_sorter.sv
module sim_keyed_sorter;
    import ksort_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MAXOBJ     = 32;
    localparam int NVEC       = 6;
    // mask(16) thresh(12) count(6) seed(8)
    localparam logic [41:0] VECS [NVEC] = '{
        {16'h0001, 12'd12,  6'd5,  8'd1},
        {16'h0003, 12'd25,  6'd8,  8'd2},
        {16'h8000, 12'd0,   6'd16, 8'd3},
        {16'hFFFF, 12'd230, 6'd12, 8'd4},
        {16'h0000, 12'd0,   6'd4,  8'd5},
        {16'h00F0, 12'd60,  6'd7,  8'd6}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [NQ-1:0]    cfg_mask = '0;
    logic [KW-1:0]    cfg_thresh = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [OBJ_W-1:0] in_obj = '0;
    logic             in_last = 1'b0;
    logic             out_valid;
    logic [OBJ_W-1:0] out_obj;
    logic [KW-1:0]    out_key;
    logic             out_last;
    logic             cnt_valid;
    logic [CW-1:0]    cnt_value;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [OBJ_W-1:0] objs [MAXOBJ];
    int               kx   [MAXOBJ];
    int               ord  [MAXOBJ];

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_sorter u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mask(cfg_mask), .cfg_thresh(cfg_thresh),
        .in_valid(in_valid), .in_ready(in_ready), .in_obj(in_obj), .in_last(in_last),
        .out_valid(out_valid), .out_obj(out_obj), .out_key(out_key), .out_last(out_last),
        .cnt_valid(cnt_valid), .cnt_value(cnt_value)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [OBJ_W-1:0] make_obj(input int mode, input int seed, input int j);
        logic [OBJ_W-1:0] o;
        for (int q = 0; q < NQ; q++) begin
            if (mode == 1) o[q*QW +: QW] = (q == 0) ? ((j % 2) ? 8'd9 : 8'd4) : 8'(j + q);
            else           o[q*QW +: QW] = 8'(((seed * 17 + j * 5 + q * 3) * 13) % 29);
        end
        return o;
    endfunction

    // Requirement-level model: masked byte sum, stable descending order, threshold count.
    task automatic run_event(input int mode, input bit do_cfg, input logic [15:0] mask,
                             input int thr, input int n, input int seed,
                             input bit junk, input string tag);
        int nst;
        int exp_cnt;
        logic [OBJ_W-1:0] cur;
        int k;
        if (do_cfg) begin
            @(negedge clk);
            cfg_we = 1'b1; cfg_mask = mask; cfg_thresh = KW'(thr);
            @(negedge clk);
            cfg_we = 1'b0;
        end
        nst = (n > DEPTH) ? DEPTH : n;
        exp_cnt = 0;
        for (int j = 0; j < n; j++) begin
            objs[j] = make_obj(mode, seed, j);
            kx[j] = 0;
            for (int q = 0; q < NQ; q++) if (mask[q]) kx[j] += int'(objs[j][q*QW +: QW]);
        end
        for (int j = 0; j < nst; j++) begin
            if (kx[j] >= thr) exp_cnt++;
            ord[j] = j;
        end
        for (int i = 1; i < nst; i++) begin
            k = i;
            while (k > 0 && kx[ord[k-1]] < kx[ord[k]]) begin
                int t = ord[k]; ord[k] = ord[k-1]; ord[k-1] = t;
                k--;
            end
        end
        for (int j = 0; j < n; j++) begin
            in_valid = 1'b1; in_obj = objs[j]; in_last = (j == n - 1);
            check(in_ready == 1'b1, "R5", {tag, " in_ready while filling"}, in_ready, 1);
            @(negedge clk);
        end
        in_valid = junk; in_last = 1'b0;
        in_obj = {OBJ_W{1'b1}};
        for (int i = 0; i < nst; i++) begin
            check(out_valid == 1'b1, "R6", {tag, " out_valid during output"}, out_valid, 1);
            check(in_ready == 1'b0, "R9", {tag, " in_ready low during output"}, in_ready, 0);
            cur = out_obj;
            check(cur == objs[ord[i]], "R3", {tag, " object order (R4 ties)"}, i, ord[i]);
            check(out_key == KW'(kx[ord[i]]), "R2", {tag, " key value"}, out_key, kx[ord[i]]);
            check(out_last == (i == nst - 1), "R6", {tag, " out_last marking"}, out_last, i == nst - 1);
            @(negedge clk);
        end
        check(out_valid == 1'b0, "R6", {tag, " output length"}, out_valid, 0);
        check(cnt_valid == 1'b1, "R7", {tag, " count pulse"}, cnt_valid, 1);
        check(cnt_value == CW'(exp_cnt), "R7", {tag, " count value"}, cnt_value, exp_cnt);
        @(negedge clk);
        in_valid = 1'b0;
        check(cnt_valid == 1'b0, "R7", {tag, " count single cycle"}, cnt_valid, 0);
        check(in_ready == 1'b1, "R9", {tag, " ready again"}, in_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid, "R1", "out_valid after reset", out_valid, 0);
        check(!cnt_valid, "R1", "cnt_valid after reset", cnt_valid, 0);
        check(in_ready,   "R1", "in_ready after reset", in_ready, 1);

        // R1: reset mask selects quantity 0, threshold 0
        run_event(0, 1'b0, 16'h0001, 0, 6, 9, 1'b0, "R1 reset config");

        // table walk: R2 R3 R6 R7 R10 under several masks
        for (int v = 0; v < NVEC; v++) begin
            run_event(0, 1'b1, VECS[v][41:26], int'(VECS[v][25:14]),
                      int'(VECS[v][13:8]), int'(VECS[v][7:0]), 1'b0, "R10 table");
        end

        // R4: repeated keys distinguished by other fields
        run_event(1, 1'b1, 16'h0001, 5, 9, 0, 1'b0, "R4 ties");
        // single-object event
        run_event(0, 1'b1, 16'h0010, 0, 1, 11, 1'b0, "R6 single");
        // R8: overflow, only the first DEPTH kept
        run_event(0, 1'b1, 16'h0006, 20, 19, 12, 1'b0, "R8 overflow");
        // R9: input offered during output is ignored, next event must be clean
        run_event(0, 1'b1, 16'h0101, 15, 5, 13, 1'b1, "R9 junk");
        run_event(0, 1'b1, 16'h0101, 15, 3, 14, 1'b0, "R9 after junk");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule